// File: doc/BRIEF.md
# Display Line Latch with Column Polarity

This block sits between the column shift register of a display source driver and its per-column converters. When the line strobe rises, it copies a fully loaded parallel column register into an output line latch, so every column receives its new gray-level code on the same clock edge. At that edge it also gives each column a reference-half select bit. Odd and even columns receive opposite halves, and a polarity input chooses which half goes where. This yields dot inversion within one device.

The strobe, the polarity input and the data-marker pulses are sampled synchronously on the system clock. A shift tick marks one shift-clock period. The first and last markers, qualified by the tick, tag the first and last data triples of a line.

A timing monitor counts shift ticks after the last triple. It raises a one-cycle error pulse when the strobe arrives too early, or when the next line starts before the minimum blanking interval has passed. A test-select input forces the output-drive enable low, and the line latch keeps working while it is high.

Top module: `line_latch_top`

## Requirements
- R1: Column c occupies bits [c*BITS +: BITS] of the data and code buses. On the clock edge that first samples the strobe high after it was low, `code_o` takes the value of `col_data_i`. At every other edge it holds, including while the strobe stays high and when `col_data_i` changes.
- R2: Column index 0 is column number 1, an odd column. When the latched polarity is 1, `hi_sel_o[c]` is 1 for even c (odd-numbered columns) and 0 for odd c.
- R3: When the latched polarity is 0, the assignment is swapped: `hi_sel_o[c]` is 0 for even c and 1 for odd c.
- R4: `pol_i` is sampled only on the strobe-rise edge. A change between strobes leaves `hi_sel_o` unchanged.
- R5: After reset, `code_o` and `hi_sel_o` are zero and `line_valid_o` is low. `line_valid_o` goes high at the first strobe rise and stays high afterwards.
- R6: One edge after each clock, `out_en_o` equals (line valid after that edge) AND NOT `test_mode_i`. It is therefore low whenever the test select is high.
- R7: At least MIN_LAST shift ticks (default 1) must fall strictly after the last-data tick and before the edge that sees the strobe rise. If fewer do, `timing_err_o` is high for exactly the cycle after that edge.
- R8: At least MIN_BLANK shift ticks (default 3) must fall strictly between the last-data tick and the next first-data tick. If fewer do, `timing_err_o` pulses in the cycle after the first-data tick.
- R9: No rule is checked after reset until a last-data tick has been seen, nor after a first-data tick until the next last-data tick. Compliant timing never raises `timing_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| col_data_i | input | NCOL*BITS | Loaded column register contents |
| shift_tick_i | input | 1 | One pulse per shift-clock period |
| first_i | input | 1 | Marks the first data triple of a line (with tick) |
| last_i | input | 1 | Marks the last data triple of a line (with tick) |
| strobe_i | input | 1 | Line strobe level |
| pol_i | input | 1 | Polarity select |
| test_mode_i | input | 1 | High selects test mode, output drive off |
| code_o | output | NCOL*BITS | Latched gray-level codes |
| hi_sel_o | output | NCOL | Per-column reference half, 1 = upper set |
| line_valid_o | output | 1 | A line has been latched since reset |
| out_en_o | output | 1 | Output drive enable |
| timing_err_o | output | 1 | One-cycle pulse on a blanking rule violation |

## Verification
The bench builds the block with eight columns of six bits, MIN_LAST of 1 and MIN_BLANK of 3. With eight columns, both parities appear four times each. A 48-bit random line pattern can be compared in full on every cycle. With the small gap limits, random gaps of zero to four ticks land on both sides of each rule, so both error pulses and compliant lines occur many times.

// File: rtl/line_latch_pkg.sv
package line_latch_pkg;

  typedef enum logic {
    MON_IDLE  = 1'b0,
    MON_ARMED = 1'b1
  } mon_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o
);

  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);  // R1

endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int unsigned NCOL = 8,
  parameter int unsigned BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise_i,
  input  logic                 pol_i,
  input  logic [NCOL*BITS-1:0] data_i,
  output logic [NCOL*BITS-1:0] code_o,
  output logic [NCOL-1:0]      hi_o,
  output logic                 valid_o
);

  localparam int unsigned W = NCOL * BITS;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam logic ODD_IDX = 1'(c % 2);

    always_ff @(posedge clk) begin
      if (rst) begin
        code_o[c*BITS +: BITS] <= '0;
        hi_o[c]                <= 1'b0;
      end else if (rise_i) begin
        code_o[c*BITS +: BITS] <= data_i[c*BITS +: BITS];
        hi_o[c]                <= pol_i ^ ODD_IDX;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         valid_o <= 1'b0;
    else if (rise_i) valid_o <= 1'b1;
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(code_o));  // R1
  AST_POL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> hi_o[0] == $past(pol_i));  // R2
  AST_PRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (code_o == W'(0)) && (hi_o == '0));  // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);  // R5

endmodule

// File: rtl/blank_monitor.sv
module blank_monitor
  import line_latch_pkg::*;
#(
  parameter int unsigned MIN_LAST  = 1,
  parameter int unsigned MIN_BLANK = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic first_i,
  input  logic last_i,
  input  logic rise_i,
  output logic err_o
);

  localparam int unsigned SAT = max_u(MIN_LAST, MIN_BLANK);
  localparam int unsigned CW  = cnt_width(SAT);
  localparam logic [CW-1:0] SAT_V   = CW'(SAT);
  localparam logic [CW-1:0] LAST_V  = CW'(MIN_LAST);
  localparam logic [CW-1:0] BLANK_V = CW'(MIN_BLANK);

  logic [CW-1:0] cnt_q;
  mon_state_e    st_q;
  logic          early_strobe, short_blank;

  assign early_strobe = rise_i && (st_q == MON_ARMED) && (cnt_q < LAST_V);
  assign short_blank  = tick_i && first_i && (st_q == MON_ARMED) && (cnt_q < BLANK_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= SAT_V;
      st_q  <= MON_IDLE;
      err_o <= 1'b0;
    end else begin
      err_o <= early_strobe | short_blank;
      if (tick_i && last_i) begin
        cnt_q <= '0;
        st_q  <= MON_ARMED;
      end else begin
        if (tick_i && (cnt_q < SAT_V)) cnt_q <= cnt_q + 1'b1;
        if (tick_i && first_i)         st_q  <= MON_IDLE;
      end
    end
  end

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(rise_i || (tick_i && first_i)));  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == MON_IDLE) |=> !err_o);  // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SAT_V);  // R8

endmodule

// File: rtl/line_latch_top.sv
module line_latch_top #(
  parameter int unsigned NCOL      = 8,
  parameter int unsigned BITS      = 6,
  parameter int unsigned MIN_LAST  = 1,
  parameter int unsigned MIN_BLANK = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCOL*BITS-1:0] col_data_i,
  input  logic                 shift_tick_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic                 strobe_i,
  input  logic                 pol_i,
  input  logic                 test_mode_i,
  output logic [NCOL*BITS-1:0] code_o,
  output logic [NCOL-1:0]      hi_sel_o,
  output logic                 line_valid_o,
  output logic                 out_en_o,
  output logic                 timing_err_o
);

  logic rise;

  strobe_edge i_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .rise_o   (rise)
  );

  line_store #(.NCOL(NCOL), .BITS(BITS)) i_store (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .pol_i   (pol_i),
    .data_i  (col_data_i),
    .code_o  (code_o),
    .hi_o    (hi_sel_o),
    .valid_o (line_valid_o)
  );

  blank_monitor #(.MIN_LAST(MIN_LAST), .MIN_BLANK(MIN_BLANK)) i_mon (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (shift_tick_i),
    .first_i (first_i),
    .last_i  (last_i),
    .rise_i  (rise),
    .err_o   (timing_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) out_en_o <= 1'b0;
    else     out_en_o <= (line_valid_o | rise) & ~test_mode_i;
  end

  AST_EN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_en_o |-> line_valid_o);  // R6
  AST_TEST_OFF: assert property (@(posedge clk) disable iff (rst)
    test_mode_i |=> !out_en_o);  // R6

endmodule

// File: tb/test_line_latch_top.sv
module test_line_latch_top;
  localparam int NCOL = 8;
  localparam int BITS = 6;
  localparam int W    = NCOL * BITS;
  localparam int MIN_LAST  = 1;
  localparam int MIN_BLANK = 3;
  localparam int SAT = 3;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] col_data;
  logic tick, first, last, strobe, pol, test_mode;
  logic [W-1:0] code;
  logic [NCOL-1:0] hi_sel;
  logic valid, out_en, terr;

  always #4 clk = ~clk;

  line_latch_top #(.NCOL(NCOL), .BITS(BITS), .MIN_LAST(MIN_LAST), .MIN_BLANK(MIN_BLANK))
  i_line_latch_top (
    .clk(clk), .rst(rst), .col_data_i(col_data), .shift_tick_i(tick),
    .first_i(first), .last_i(last), .strobe_i(strobe), .pol_i(pol),
    .test_mode_i(test_mode), .code_o(code), .hi_sel_o(hi_sel),
    .line_valid_o(valid), .out_en_o(out_en), .timing_err_o(terr)
  );

  int checks = 0, fails = 0;
  logic done = 1'b0;

  // expected state
  logic [W-1:0]    e_code;
  logic [NCOL-1:0] e_hi;
  logic e_valid, e_en, e_pol, armed, s_prev;
  int cnt;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NCOL-1:0] pol_pattern(logic p);
    logic [NCOL-1:0] v;
    for (int i = 0; i < NCOL; i++) v[i] = p ^ (i % 2 == 1);
    return v;
  endfunction

  function automatic logic [W-1:0] rnd_data();
    logic [63:0] r = {$urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  // one clock: inputs applied now, outputs checked at the next falling edge
  task automatic step(logic t, logic f, logic l, logic s);
    logic rise, e_err;
    string etag;
    tick = t; first = f; last = l; strobe = s;
    rise  = s && !s_prev;
    e_err = 1'b0;
    etag  = "R9";
    if (rise && armed && cnt < MIN_LAST) begin e_err = 1'b1; etag = "R7"; end
    if (t && f && armed && cnt < MIN_BLANK) begin e_err = 1'b1; etag = "R8"; end
    if (rise) begin
      e_code = col_data; e_hi = pol_pattern(pol); e_valid = 1'b1; e_pol = pol;
    end
    e_en = e_valid && !test_mode;
    if (t && l) begin cnt = 0; armed = 1'b1; end
    else begin
      if (t && cnt < SAT) cnt++;
      if (t && f) armed = 1'b0;
    end
    s_prev = s;
    @(negedge clk);
    chk("R1 code", 64'(code), 64'(e_code));
    chk(e_pol ? "R2 hi_sel" : "R3 hi_sel", 64'(hi_sel), 64'(e_hi));
    chk("R5 valid", 64'(valid), 64'(e_valid));
    chk("R6 out_en", 64'(out_en), 64'(e_en));
    chk(etag, 64'(terr), 64'(e_err));
  endtask

  // one display line: data ticks, gap, strobe, blanking
  task automatic line(int ndata, int gap, int hold, int blank, logic p, logic tm, bit idles);
    step(1, 1, 0, 0);
    for (int i = 0; i < ndata - 2; i++) begin
      if (idles && ($urandom % 3 == 0)) step(0, 0, 0, 0);
      step(1, 0, 0, 0);
    end
    col_data = rnd_data();
    step(1, 0, 1, 0);
    for (int i = 0; i < gap; i++) step(1, 0, 0, 0);
    pol = p; test_mode = tm;
    step(0, 0, 0, 1);
    // R1/R4: changes while strobe held high and afterwards must not be taken
    col_data = rnd_data(); pol = ~p;
    for (int i = 0; i < hold; i++) step(1, 0, 0, 1);
    step(0, 0, 0, 0);
    for (int i = 0; i < blank; i++) step(1, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; tick = 0; first = 0; last = 0; strobe = 0; pol = 0; test_mode = 0;
    col_data = '0;
    e_code = '0; e_hi = '0; e_valid = 0; e_en = 0; e_pol = 1'b1;
    armed = 0; s_prev = 0; cnt = SAT;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    chk("R5 code reset", 64'(code), 64'd0);
    chk("R5 hi reset", 64'(hi_sel), 64'd0);
    chk("R5 valid reset", 64'(valid), 64'd0);
    chk("R6 en reset", 64'(out_en), 64'd0);
    step(1, 0, 0, 0);
    // R9: strobe before any last-data tick is not checked
    col_data = rnd_data(); pol = 1'b1;
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    // compliant lines, both polarities (R2, R3)
    line(4, 1, 1, 3, 1'b1, 1'b0, 0);
    line(5, 2, 0, 2, 1'b0, 1'b0, 0);
    // R7: strobe right after last tick
    line(3, 0, 1, 4, 1'b1, 1'b0, 0);
    // R8: short blanking (0 gap ticks + 1 blank = 1 tick)
    line(3, 0, 0, 1, 1'b0, 1'b0, 0);
    // R6: test mode turns drive off
    line(4, 1, 1, 3, 1'b1, 1'b1, 0);
    // R4: pol toggles between strobes, hi_sel must hold
    for (int i = 0; i < 4; i++) begin pol = ~pol; step(0, 0, 0, 0); end
    line(4, 3, 0, 0, 1'b0, 1'b0, 0);
    // random lines
    for (int n = 0; n < 60; n++)
      line(2 + int'($urandom % 4), int'($urandom % 4), int'($urandom % 3),
           int'($urandom % 5), 1'($urandom), 1'($urandom % 5 == 0), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule